// File: doc/BRIEF.md
# HDLC Frame Transmitter with Tagged Transmit Queue

This block turns bytes from a small transmit queue into a bit-serial HDLC line. Each queued byte carries two tag bits. An end-of-frame tag makes the transmitter append the frame check sequence and a closing flag directly after that byte. An abort tag makes it drop the frame it belongs to. Because frame boundaries travel with the data, several complete frames can wait in the queue at the same time. The host does not set the tags on the write port itself. It arms them with one-cycle request pulses, and the next write consumes them.

The serial side produces one line bit every `CLKS_PER_BIT` clocks and marks each bit with a strobe. Inside a frame, a zero is inserted after five consecutive ones. When no frame is ready, the line carries either continuous ones or back-to-back flags. A transparent mode bypasses all framing and shifts raw bytes out. A 2-bit level code reports the queue fill state against one of two thresholds.

Top module: `hdlc_tx_top`

## Requirements
- R1: A frame is sent as an opening flag 0x7E, then the data bytes, then two FCS bytes, then a closing flag 0x7E. Every byte goes out least significant bit first. Inside data and FCS, a 0 is inserted after any five consecutive 1s. Flags are never stuffed. `tx_stb` is high for exactly one clock per line bit, and `tx_d` holds that bit.
- R2: The FCS is CRC-16-CCITT in reflected form (polynomial 0x8408), preset to 0xFFFF. It is sent inverted, low byte first. Running the same CRC over the received data plus FCS leaves the residue 0xF0B8.
- R3: A pulse on `eop_req` or `abort_req` arms the matching tag for the next accepted write, or for a write in the same cycle. Any write clears both armed tags, so the following byte is untagged.
- R4: A byte tagged end-of-frame is followed directly by the FCS and the closing flag. Frames queued back to back are sent as separate frames in write order.
- R5: A byte tagged abort is not sent. In its place the line carries at least seven consecutive 1s. The queued bytes after it are discarded up to and including the next end-of-frame byte.
- R6: If the queue runs empty inside a frame before an end-of-frame byte, the transmitter sends an abort (at least seven 1s) and ends the frame.
- R7: While `tx_enable` is low, no new frame is started. Clearing it during a frame lets that frame finish. Setting it starts a waiting frame without delay.
- R8: When no frame is in progress, the line carries all 1s if `flag_fill` is 0, or continuous flags if it is 1.
- R9: `fifo_code` reports the queue level: 2'b10 when empty, 2'b11 when below the threshold, 2'b01 when at or above the threshold but not full, and 2'b00 when full. The threshold is 5 bytes when `thr_high` is 0 and 15 bytes when it is 1.
- R10: When `transparent` is 1, queued bytes are shifted out LSB first with no flags, no zero insertion, no FCS and no aborts. With the queue empty, the line carries 1s.
- R11: A write while the queue holds `DEPTH` (16) bytes is ignored.
- R12: During reset, `tx_d` is 1 and `fifo_code` is 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_byte | input | 8 | Byte to queue |
| eop_req | input | 1 | Arms the end-of-frame tag for the next write |
| abort_req | input | 1 | Arms the abort tag for the next write |
| tx_enable | input | 1 | Allows new frames to start |
| flag_fill | input | 1 | Idle line type: 0 sends ones, 1 sends flags |
| transparent | input | 1 | Raw byte shifting without framing |
| thr_high | input | 1 | Selects the high level threshold |
| tx_d | output | 1 | Serial line data |
| tx_stb | output | 1 | One-clock strobe for each line bit |
| fifo_code | output | 2 | Encoded queue level |

## Verification
The hardest case to reach is an abort tag that lands inside a queue already holding a later, good frame. The discard must stop exactly at the aborted frame's end-of-frame byte, and the next frame must still come out intact. The bench reaches this by loading the whole sequence with `tx_enable` low and then enabling, so the queue contents are fixed before the transmitter reads any byte. Underrun is reached by writing a short unterminated frame with the transmitter running. Stuffing directly before the closing flag is reached by payloads of all ones. A bench-side receiver removes stuffing, detects flags and aborts, and checks the CRC residue.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef struct packed {
    logic       eop;
    logic       abort;
    logic [7:0] data;
  } tx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS_LO,
    ST_FCS_HI,
    ST_CLOSE
  } tx_state_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ONES_BYTE = 8'hFF;

  localparam logic [1:0] LVL_FULL  = 2'b00;
  localparam logic [1:0] LVL_HIGH  = 2'b01;
  localparam logic [1:0] LVL_LOW   = 2'b11;
  localparam logic [1:0] LVL_EMPTY = 2'b10;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  tx_entry_t                  wr_entry,
  input  logic                       rd_en,
  output tx_entry_t                  head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  tx_entry_t         mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              do_wr, do_rd;

  assign do_wr = wr_en && (count_q != CW'(DEPTH));
  assign do_rd = rd_en && (count_q != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = count_q;
  assign empty = (count_q == '0);

  // R11: a full queue that is not read keeps its level whatever is written
  p_full_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (count_q == CW'(DEPTH) && !rd_en) |=> (count_q == CW'(DEPTH)));

endmodule

// File: rtl/hdlc_tx_level.sv
module hdlc_tx_level
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int LOW_THR  = 5,
  parameter int HIGH_THR = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic                       thr_high,
  output logic [1:0]                 code
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] thr_v;
  logic [1:0]    code_q;

  assign thr_v = thr_high ? CW'(HIGH_THR) : CW'(LOW_THR);

  always_ff @(posedge clk) begin
    if (rst)                         code_q <= LVL_EMPTY;
    else if (count == '0)            code_q <= LVL_EMPTY;
    else if (count == CW'(DEPTH))    code_q <= LVL_FULL;
    else if (count >= thr_v)         code_q <= LVL_HIGH;
    else                             code_q <= LVL_LOW;
  end

  assign code = code_q;

  // R9: the empty and full codes only follow an empty or full queue
  p_empty_code_r9: assert property (@(posedge clk) disable iff (rst)
    (code_q == LVL_EMPTY) |-> ($past(count) == '0));
  p_full_code_r9: assert property (@(posedge clk) disable iff (rst)
    (code_q == LVL_FULL) |-> ($past(count) == CW'(DEPTH)));

endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter logic [15:0] POLY = 16'h8408
) (
  input  logic [15:0] crc_in,
  input  logic [7:0]  data,
  output logic [15:0] crc_out
);
  always_comb begin
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ POLY;
      else                c = c >> 1;
    end
    crc_out = c;
  end
endmodule

// File: rtl/hdlc_tx_top.sv
module hdlc_tx_top
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int LOW_THR      = 5,
  parameter int HIGH_THR     = 15,
  parameter int CLKS_PER_BIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       eop_req,
  input  logic       abort_req,
  input  logic       tx_enable,
  input  logic       flag_fill,
  input  logic       transparent,
  input  logic       thr_high,
  output logic       tx_d,
  output logic       tx_stb,
  output logic [1:0] fifo_code
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = $clog2(CLKS_PER_BIT);

  // tag request latches
  logic      eop_pend_q, abort_pend_q;
  tx_entry_t wr_ent;

  assign wr_ent = '{eop: eop_pend_q | eop_req, abort: abort_pend_q | abort_req, data: wr_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      eop_pend_q   <= 1'b0;
      abort_pend_q <= 1'b0;
    end else if (wr_en) begin
      eop_pend_q   <= 1'b0;
      abort_pend_q <= 1'b0;
    end else begin
      if (eop_req)   eop_pend_q   <= 1'b1;
      if (abort_req) abort_pend_q <= 1'b1;
    end
  end

  // queue and level
  tx_entry_t     head;
  logic [CW-1:0] count;
  logic          empty, rd_en;

  hdlc_tx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_entry(wr_ent), .rd_en(rd_en),
    .head(head), .count(count), .empty(empty)
  );

  hdlc_tx_level #(.DEPTH(DEPTH), .LOW_THR(LOW_THR), .HIGH_THR(HIGH_THR)) i_level (
    .clk(clk), .rst(rst), .count(count), .thr_high(thr_high), .code(fifo_code)
  );

  // bit timing and line state
  logic [DW-1:0] div_q;
  logic          tick, load;
  logic [7:0]    sh_q;
  logic [3:0]    bits_left_q;
  logic [2:0]    ones_q;
  logic          stuff_q, drop_q, tx_d_q, tx_stb_q;
  tx_state_e     state_q;
  logic [15:0]   crc_q, crc_nx;

  assign tick = (div_q == DW'(CLKS_PER_BIT - 1));
  assign load = !tick && (bits_left_q == 4'd0);

  hdlc_tx_crc i_crc (.crc_in(crc_q), .data(head.data), .crc_out(crc_nx));

  // next unit selection
  logic [7:0] ld_byte;
  logic       ld_stuff, ld_pop, crc_init, crc_step, drop_set;
  tx_state_e  nxt_state;

  always_comb begin
    ld_byte   = ONES_BYTE;
    ld_stuff  = 1'b0;
    ld_pop    = 1'b0;
    crc_init  = 1'b0;
    crc_step  = 1'b0;
    drop_set  = 1'b0;
    nxt_state = state_q;
    if (transparent) begin
      nxt_state = ST_IDLE;
      if (tx_enable && !empty && !drop_q) begin
        ld_byte = head.data;
        ld_pop  = 1'b1;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tx_enable && !empty && !drop_q) begin
            ld_byte   = FLAG_BYTE;
            crc_init  = 1'b1;
            nxt_state = ST_DATA;
          end else begin
            ld_byte = flag_fill ? FLAG_BYTE : ONES_BYTE;
          end
        end
        ST_DATA: begin
          if (empty) begin
            ld_byte   = ONES_BYTE;
            nxt_state = ST_IDLE;
          end else if (head.abort) begin
            ld_pop    = 1'b1;
            ld_byte   = ONES_BYTE;
            drop_set  = !head.eop;
            nxt_state = ST_IDLE;
          end else begin
            ld_pop    = 1'b1;
            ld_byte   = head.data;
            ld_stuff  = 1'b1;
            crc_step  = 1'b1;
            nxt_state = head.eop ? ST_FCS_LO : ST_DATA;
          end
        end
        ST_FCS_LO: begin
          ld_byte   = ~crc_q[7:0];
          ld_stuff  = 1'b1;
          nxt_state = ST_FCS_HI;
        end
        ST_FCS_HI: begin
          ld_byte   = ~crc_q[15:8];
          ld_stuff  = 1'b1;
          nxt_state = ST_CLOSE;
        end
        default: begin
          ld_byte   = FLAG_BYTE;
          nxt_state = ST_IDLE;
        end
      endcase
    end
  end

  assign rd_en = (load && ld_pop) || (drop_q && !empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= '0;
      tx_d_q      <= 1'b1;
      tx_stb_q    <= 1'b0;
      sh_q        <= ONES_BYTE;
      bits_left_q <= 4'd0;
      ones_q      <= 3'd0;
      stuff_q     <= 1'b0;
      state_q     <= ST_IDLE;
      crc_q       <= 16'hFFFF;
      drop_q      <= 1'b0;
    end else begin
      div_q    <= tick ? '0 : div_q + 1'b1;
      tx_stb_q <= tick;
      if (tick) begin
        if (ones_q == 3'd5) begin
          tx_d_q <= 1'b0;
          ones_q <= 3'd0;
        end else if (bits_left_q != 4'd0) begin
          tx_d_q      <= sh_q[0];
          sh_q        <= {1'b1, sh_q[7:1]};
          bits_left_q <= bits_left_q - 1'b1;
          ones_q      <= (stuff_q && sh_q[0]) ? ones_q + 1'b1 : 3'd0;
        end else begin
          tx_d_q <= 1'b1;
        end
      end else if (load) begin
        sh_q        <= ld_byte;
        bits_left_q <= 4'd8;
        stuff_q     <= ld_stuff;
        state_q     <= nxt_state;
        if (crc_init)      crc_q <= 16'hFFFF;
        else if (crc_step) crc_q <= crc_nx;
      end
      if (load && drop_set)                drop_q <= 1'b1;
      else if (drop_q && !empty && head.eop) drop_q <= 1'b0;
    end
  end

  assign tx_d   = tx_d_q;
  assign tx_stb = tx_stb_q;

  // R1: each line bit gets a single-clock strobe
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    tx_stb |=> !tx_stb);
  // R3: any write leaves no armed tag behind
  p_tag_clear_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!eop_pend_q && !abort_pend_q));
  // R7: with transmission disabled an idle transmitter stays idle
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !tx_enable) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_hdlc_tx_top.sv
module test_hdlc_tx_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, eop_req = 1'b0, abort_req = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       tx_enable = 1'b0, flag_fill = 1'b0, transparent = 1'b0, thr_high = 1'b0;
  logic       tx_d, tx_stb;
  logic [1:0] fifo_code;

  always #5 clk = ~clk;

  hdlc_tx_top i_hdlc_tx_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .eop_req(eop_req),
    .abort_req(abort_req), .tx_enable(tx_enable), .flag_fill(flag_fill),
    .transparent(transparent), .thr_high(thr_high), .tx_d(tx_d), .tx_stb(tx_stb),
    .fifo_code(fifo_code)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference receiver
  int   frames_got = 0, aborts = 0, flags = 0, zeros = 0, run_len = 0, run_max = 0;
  int   rx_ones = 0, nb = 0;
  bit   in_frame = 0;
  bit   bits_buf [1024];
  int   rx_len [32];
  bit   rx_ok  [32];
  logic [7:0] rx_dat [32][18];

  task automatic close_frame(input int n);
    logic [15:0] c;
    if (n >= 24 && (n % 8) == 0 && n <= 160 && frames_got < 32) begin
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
        if (c[0] ^ bits_buf[i]) c = (c >> 1) ^ 16'h8408;
        else                    c = c >> 1;
      end
      rx_ok[frames_got]  = (c == 16'hF0B8);
      rx_len[frames_got] = n / 8 - 2;
      for (int k = 0; k < n / 8 - 2; k++)
        for (int b = 0; b < 8; b++) rx_dat[frames_got][k][b] = bits_buf[k*8 + b];
      frames_got++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && tx_stb) begin
      if (tx_d) begin
        run_len++;
        if (run_len > run_max) run_max = run_len;
        rx_ones++;
        if (rx_ones == 7 && in_frame) begin
          if (nb >= 8) aborts++;
          in_frame = 0;
        end
        if (in_frame && nb < 1000) begin bits_buf[nb] = 1'b1; nb++; end
      end else begin
        zeros++;
        run_len = 0;
        if (rx_ones == 6) begin
          flags++;
          if (in_frame) close_frame(nb - 7);
          in_frame = 1;
          nb = 0;
        end else if (rx_ones != 5 && in_frame && nb < 1000) begin
          bits_buf[nb] = 1'b0;
          nb++;
        end
        rx_ones = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_byte = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_eop();
    eop_req = 1'b1; @(negedge clk); eop_req = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] first, input logic [7:0] step);
    for (int i = 0; i < len; i++) begin
      if (i == len - 1) pulse_eop();
      wr(first + 8'(i) * step);
    end
  endtask

  task automatic wait_frames(input int target, input string req);
    int t = 0;
    while (frames_got < target && t < 30000) begin @(negedge clk); t++; end
    check(frames_got >= target, req, frames_got, target);
  endtask

  task automatic check_frame(input int idx, input int len, input logic [7:0] first,
                             input logic [7:0] step, input string req);
    bit same = 1;
    if (idx >= 32) begin check(0, req, idx, 31); return; end
    check(rx_len[idx] == len, req, rx_len[idx], len);
    for (int k = 0; k < len && k < 18; k++)
      if (rx_dat[idx][k] !== first + 8'(k) * step) same = 0;
    check(same, req, int'(same), 1);
    check(rx_ok[idx], "R2", int'(rx_ok[idx]), 1);
  endtask

  // rows: len[23:16], first byte[15:8], step[7:0]
  localparam logic [23:0] VEC [6] = '{
    {8'd3, 8'h00, 8'h00},
    {8'd4, 8'hFF, 8'h00},
    {8'd5, 8'h7E, 8'h00},
    {8'd2, 8'h01, 8'h02},
    {8'd8, 8'h3F, 8'h11},
    {8'd1, 8'hA5, 8'h00}
  };

  initial begin
    int base, snap_a, snap_f, snap_fl;
    repeat (3) @(negedge clk);
    check(tx_d == 1'b1, "R12", int'(tx_d), 1);
    check(fifo_code == 2'b10, "R12", int'(fifo_code), 2);
    rst = 1'b0;
    @(negedge clk);

    // R9 and R11: level codes with transmission disabled
    for (int i = 0; i < 4; i++) wr(8'(i) * 8'd17 + 8'd3);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b11, "R9", int'(fifo_code), 3);
    wr(8'd4 * 8'd17 + 8'd3);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b01, "R9", int'(fifo_code), 1);
    thr_high = 1'b1;
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b11, "R9", int'(fifo_code), 3);
    for (int i = 5; i < 14; i++) wr(8'(i) * 8'd17 + 8'd3);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b11, "R9", int'(fifo_code), 3);
    wr(8'd14 * 8'd17 + 8'd3);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b01, "R9", int'(fifo_code), 1);
    pulse_eop();
    wr(8'd15 * 8'd17 + 8'd3);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b00, "R9", int'(fifo_code), 0);
    pulse_eop();
    wr(8'hAA);
    repeat (2) @(negedge clk);
    check(fifo_code == 2'b00, "R11", int'(fifo_code), 0);
    thr_high = 1'b0;
    tx_enable = 1'b1;
    wait_frames(1, "R11");
    check_frame(0, 16, 8'd3, 8'd17, "R11");
    repeat (400) @(negedge clk);
    check(frames_got == 1, "R11", frames_got, 1);
    check(fifo_code == 2'b10, "R9", int'(fifo_code), 2);

    // table of frames: R1 stuffing and flags, R4 end tag
    foreach (VEC[r]) begin
      base = frames_got;
      send_frame(int'(VEC[r][23:16]), VEC[r][15:8], VEC[r][7:0]);
      wait_frames(base + 1, "R4");
      check_frame(base, int'(VEC[r][23:16]), VEC[r][15:8], VEC[r][7:0], "R1");
    end

    // R3 tag request clears after one write; two frames queued at once (R4)
    base = frames_got;
    pulse_eop(); wr(8'h11);
    wr(8'h21);
    pulse_eop(); wr(8'h22);
    wait_frames(base + 2, "R3");
    check_frame(base, 1, 8'h11, 8'h00, "R3");
    check_frame(base + 1, 2, 8'h21, 8'h01, "R3");

    // R5 abort tag inside a queued frame, good frame behind it
    repeat (200) @(negedge clk);
    tx_enable = 1'b0;
    repeat (100) @(negedge clk);
    base = frames_got; snap_a = aborts;
    wr(8'h40); wr(8'h41);
    pulse_abort(); wr(8'h42);
    wr(8'h43);
    pulse_eop(); wr(8'h44);
    wr(8'h45);
    pulse_eop(); wr(8'h46);
    tx_enable = 1'b1;
    wait_frames(base + 1, "R5");
    check_frame(base, 2, 8'h45, 8'h01, "R5");
    check(aborts == snap_a + 1, "R5", aborts, snap_a + 1);
    repeat (400) @(negedge clk);
    check(frames_got == base + 1, "R5", frames_got, base + 1);

    // R6 underrun
    base = frames_got; snap_a = aborts;
    wr(8'h5A); wr(8'hC3);
    repeat (400) @(negedge clk);
    check(aborts == snap_a + 1, "R6", aborts, snap_a + 1);
    check(frames_got == base, "R6", frames_got, base);
    send_frame(2, 8'h90, 8'h01);
    wait_frames(base + 1, "R6");
    check_frame(base, 2, 8'h90, 8'h01, "R6");

    // R7 enable gating
    repeat (200) @(negedge clk);
    tx_enable = 1'b0;
    repeat (100) @(negedge clk);
    base = frames_got;
    send_frame(3, 8'h60, 8'h03);
    repeat (400) @(negedge clk);
    check(frames_got == base, "R7", frames_got, base);
    check(fifo_code == 2'b11, "R7", int'(fifo_code), 3);
    tx_enable = 1'b1;
    wait_frames(base + 1, "R7");
    check_frame(base, 3, 8'h60, 8'h03, "R7");
    repeat (200) @(negedge clk);
    send_frame(8, 8'h80, 8'h05);
    repeat (100) @(negedge clk);
    tx_enable = 1'b0;
    wait_frames(base + 2, "R7");
    check_frame(base + 1, 8, 8'h80, 8'h05, "R7");
    tx_enable = 1'b1;

    // R8 idle line types
    repeat (200) @(negedge clk);
    flag_fill = 1'b0;
    repeat (50) @(negedge clk);
    run_max = 0; snap_fl = flags;
    repeat (200) @(negedge clk);
    check(run_max >= 40, "R8", run_max, 40);
    check(flags == snap_fl, "R8", flags, snap_fl);
    flag_fill = 1'b1;
    repeat (50) @(negedge clk);
    snap_fl = flags;
    repeat (200) @(negedge clk);
    check(flags >= snap_fl + 5, "R8", flags, snap_fl + 5);

    // R10 transparent mode
    transparent = 1'b1;
    repeat (100) @(negedge clk);
    zeros = 0; run_max = 0; snap_fl = flags; snap_f = frames_got;
    wr(8'h00); wr(8'hFF); wr(8'hFF);
    repeat (300) @(negedge clk);
    check(zeros == 8, "R10", zeros, 8);
    check(run_max >= 40, "R10", run_max, 40);
    check(flags == snap_fl, "R10", flags, snap_fl);
    check(frames_got == snap_f, "R10", frames_got, snap_f);
    transparent = 1'b0;
    repeat (50) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule